// File: doc/BRIEF.md
# Shadow-Sampled Timing-Error Stage Register

This block sits at one boundary of a timing-speculative pipeline. The stage output is taken twice. A main copy is taken at the clock edge. A shadow copy is taken from a later sample point that is taken to settle under every operating condition. Here the late sample arrives as its own input, `late_data`, presented in the same cycle as `in_data`. When the two copies of a valid item differ, the boundary reports an error. For one cycle it then raises `stall`, so the upstream source holds its current item. In the same cycle it raises `bubble`, so the following stage sees an empty slot. It also reloads its main copy from the shadow copy. The corrected item then moves on in the next cycle, so each error costs exactly one cycle of throughput and the pipeline always makes forward progress.

Behind the boundary sits a chain of non-computing hold stages in front of writeback. A value reaches `out_data` only after it has passed the comparison. A separate `flush_req` input models a possibly metastable error flag. When it is raised, every item in flight is discarded. Upstream is then held for a fixed number of cycles, after which the source replays its work. A saturating counter reports how many mismatches were repaired.

Top module: `tspec_pipe`

## Requirements
- R1: While reset is applied, and in the cycle after it, `out_valid`, `err`, `stall` and `bubble` are 0 and `err_count` is 0.
- R2: An item offered with `in_valid`=1 while `stall`=0 and `flush_req`=0 appears on `out_data` with `out_valid`=1 after HOLD_STAGES+1 rising edges (2 by default), for exactly one cycle when no further item follows.
- R3: When a valid item is captured whose `late_data` differs from `in_data`, `err`, `stall` and `bubble` are all 1 in the next cycle.
- R4: A mismatched item is delivered one cycle late, with the value of `late_data`. It is preceded on the output by one cycle of `out_valid`=0, and `err` is 0 in the cycle after the error cycle.
- R5: An input offered while `stall`=1 is not taken. Once `stall` falls, the held item is taken once, so the output stream keeps the item order, with no loss and no duplicate.
- R6: `err_count` rises by exactly one for each error cycle that is not flushed. It never decreases, and it saturates at 2^CNT_W-1 (255 by default).
- R7: A cycle with `flush_req`=1 discards its own input and every item in flight, so `out_valid` is 0 in the next cycle. `stall` is then 1 for exactly FLUSH_HOLD cycles (2 by default), after which input is taken again.
- R8: If `flush_req`=1 in an error cycle, no reload takes place, `stall` and `bubble` are 0 in that cycle, and `err_count` does not change.
- R9: An input cycle with `in_valid`=0 never raises `err`, whatever `late_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | DATA_W | Stage output as sampled at the clock edge |
| in_valid | input | 1 | Marks `in_data` as a real item |
| late_data | input | DATA_W | Stage output as sampled at the late point (taken to be correct) |
| flush_req | input | 1 | Error flag may be metastable: flush everything in flight |
| out_data | output | DATA_W | Verified item towards writeback |
| out_valid | output | 1 | `out_data` holds an item; 0 marks a bubble or an empty slot |
| stall | output | 1 | Upstream must hold its current item this cycle |
| bubble | output | 1 | An empty slot is sent downstream this cycle |
| err | output | 1 | Main and shadow copies of a valid item differ |
| err_count | output | CNT_W | Saturating count of repaired mismatches |

## Verification
The assertions assume a well-behaved source. The source keeps its item steady for as long as `stall` is high. It never lets short-path data reach the late sample point early, so `late_data` always belongs to the same item as `in_data`. The assertions also assume that `flush_req` only marks an error flag that is really in doubt. The stimulus keeps to these rules. It changes inputs only between edges and repeats an item until a cycle with `stall` low has taken it. It drives `late_data` as either a copy of `in_data` or a deliberately corrupted value for that same item.

// File: rtl/tspec_pkg.sv
// Shared types for the shadow-sampled stage register.
// Assumes nothing beyond being compiled before the modules that import it.
package tspec_pkg;

    // Recovery controller mode: normal running or post-flush hold.
    typedef enum logic [0:0] {
        MODE_RUN   = 1'b0,
        MODE_FLUSH = 1'b1
    } tspec_mode_t;

endpackage

// File: rtl/tspec_capture.sv
// Boundary capture: keeps a main copy and a shadow copy of the stage output
// and flags a mismatch on valid items. On reload the main copy takes the
// shadow value. Assumes the shadow sample always belongs to the same item
// as the main sample (short-path rule met by the source).
module tspec_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] late_data,
    input  logic              accept,
    input  logic              reload,
    input  logic              kill,
    output logic [DATA_W-1:0] main_data,
    output logic              main_valid,
    output logic              mismatch
);

    logic [DATA_W-1:0] shadow_q;

    // Main/shadow registers: flush, reload from shadow, capture or go empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_data  <= '0;
            main_valid <= 1'b0;
            shadow_q   <= '0;
        end else if (kill) begin
            main_valid <= 1'b0;
        end else if (reload) begin
            main_data  <= shadow_q;
        end else if (accept) begin
            main_data  <= in_data;
            main_valid <= in_valid;
            shadow_q   <= late_data;
        end else begin
            main_valid <= 1'b0;
        end
    end

    // Compare the two copies of a valid item.
    always_comb begin
        mismatch = main_valid && (main_data != shadow_q);
    end

    // R4
    reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !kill) |=> !mismatch);

endmodule

// File: rtl/tspec_recovery.sv
// Recovery controller: turns a mismatch into one cycle of stall, bubble and
// reload; turns a flush request into a kill plus FLUSH_HOLD stall cycles;
// counts repaired mismatches with saturation. Assumes flush_req is a clean
// synchronous pulse.
module tspec_recovery
    import tspec_pkg::*;
#(
    parameter int FLUSH_HOLD = 2,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mismatch,
    input  logic             flush_req,
    output logic             stall,
    output logic             bubble,
    output logic             reload,
    output logic             kill,
    output logic             accept,
    output logic [CNT_W-1:0] err_count
);

    localparam int HC_W = (FLUSH_HOLD > 1) ? $clog2(FLUSH_HOLD) : 1;
    localparam logic [HC_W-1:0]  HC_LOAD = HC_W'((FLUSH_HOLD > 0) ? FLUSH_HOLD - 1 : 0);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    tspec_mode_t      mode_q;
    logic [HC_W-1:0]  hold_q;

    // Control outputs: flush wins over error recovery.
    always_comb begin
        reload = mismatch && !flush_req;
        bubble = reload;
        kill   = flush_req;
        stall  = reload || (mode_q == MODE_FLUSH);
        accept = !stall && !flush_req;
    end

    // Mode and hold counter for the post-flush stall window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            hold_q <= '0;
        end else if (flush_req && (FLUSH_HOLD > 0)) begin
            mode_q <= MODE_FLUSH;
            hold_q <= HC_LOAD;
        end else if (mode_q == MODE_FLUSH) begin
            if (hold_q == '0) begin
                mode_q <= MODE_RUN;
            end else begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    // Saturating count of repaired mismatches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_count <= '0;
        end else if (reload && (err_count != CNT_MAX)) begin
            err_count <= err_count + CNT_ONE;
        end
    end

    // R6
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_count >= $past(err_count)));

    // R3
    bubble_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (stall && mismatch));

    // R7
    flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && (FLUSH_HOLD > 0)) |=> stall);

endmodule

// File: rtl/tspec_hold.sv
// Non-computing hold chain in front of writeback: DEPTH plain registers that
// delay verified items. A bubble enters as an empty slot; kill empties every
// stage. Assumes DEPTH >= 1 and no back-pressure from writeback.
module tspec_hold #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              bubble,
    input  logic              kill,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);

    logic [DEPTH-1:0][DATA_W-1:0] d_q;
    logic [DEPTH-1:0]             v_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage: takes the boundary item or an empty slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q[g] <= '0;
                    v_q[g] <= 1'b0;
                end else begin
                    d_q[g] <= in_data;
                    v_q[g] <= in_valid && !bubble && !kill;
                end
            end
        end else begin : g_tail
            // Later stages: shift the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_q[g] <= '0;
                    v_q[g] <= 1'b0;
                end else begin
                    d_q[g] <= d_q[g-1];
                    v_q[g] <= v_q[g-1] && !kill;
                end
            end
        end
    end

    // Last stage drives the writeback side.
    always_comb begin
        out_data  = d_q[DEPTH-1];
        out_valid = v_q[DEPTH-1];
    end

    // R4
    bubble_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !v_q[0]);

endmodule

// File: rtl/tspec_pipe.sv
// Top: shadow-sampled timing-error stage register with stall/bubble/reload
// recovery, flush on a doubtful error flag, and a hold chain before
// writeback. Assumes the source holds its item while stall is high and
// supplies the late sample of the same item in the same cycle.
module tspec_pipe #(
    parameter int DATA_W      = 16,
    parameter int HOLD_STAGES = 1,
    parameter int FLUSH_HOLD  = 2,
    parameter int CNT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] late_data,
    input  logic              flush_req,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              stall,
    output logic              bubble,
    output logic              err,
    output logic [CNT_W-1:0]  err_count
);

    logic [DATA_W-1:0] main_data;
    logic              main_valid;
    logic              mismatch;
    logic              accept;
    logic              reload;
    logic              kill;

    tspec_capture #(.DATA_W(DATA_W)) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .late_data  (late_data),
        .accept     (accept),
        .reload     (reload),
        .kill       (kill),
        .main_data  (main_data),
        .main_valid (main_valid),
        .mismatch   (mismatch)
    );

    tspec_recovery #(.FLUSH_HOLD(FLUSH_HOLD), .CNT_W(CNT_W)) rec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mismatch  (mismatch),
        .flush_req (flush_req),
        .stall     (stall),
        .bubble    (bubble),
        .reload    (reload),
        .kill      (kill),
        .accept    (accept),
        .err_count (err_count)
    );

    tspec_hold #(.DATA_W(DATA_W), .DEPTH(HOLD_STAGES)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (main_data),
        .in_valid  (main_valid),
        .bubble    (bubble),
        .kill      (kill),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // Error flag seen at the port.
    always_comb begin
        err = mismatch;
    end

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> !out_valid);

    // R9
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !stall && !flush_req) |=> !err);

endmodule

// File: tb/tspec_pipe_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tspec_pipe_tb_top;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  late_data = '0;
    logic          flush_req = 1'b0;
    logic [W-1:0]  out_data;
    logic          out_valid;
    logic          stall;
    logic          bubble;
    logic          err;
    logic [7:0]    err_count;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] got[$];

    always #2 clk = ~clk;

    tspec_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .late_data(late_data), .flush_req(flush_req), .out_data(out_data),
        .out_valid(out_valid), .stall(stall), .bubble(bubble), .err(err),
        .err_count(err_count)
    );

    // Output monitor: records every delivered item.
    always @(negedge clk) if (rst_n && out_valid) got.push_back(out_data);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offer one item; repeat it while stall is high.
    task automatic push(input logic [W-1:0] d, input logic [W-1:0] l);
        bit ws;
        in_data = d; late_data = l; in_valid = 1'b1;
        do begin
            ws = stall;
            step();
        end while (ws);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic t_reset();
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(err == 0 && stall == 0 && bubble == 0, "R1 err/stall/bubble", {err, stall, bubble}, 0);
        chk(err_count == 0, "R1 err_count", err_count, 0);
    endtask

    task automatic t_latency();
        push(16'h1234, 16'h1234);
        chk(out_valid == 0, "R2 not yet", out_valid, 0);
        step();
        chk(out_valid == 1 && out_data == 16'h1234, "R2 delivered", out_data, 16'h1234);
        step();
        chk(out_valid == 0, "R2 single cycle", out_valid, 0);
        idle(2);
    endtask

    task automatic t_clean_stream();
        int c0 = err_count;
        got.delete();
        for (int i = 0; i < 8; i++) push(W'(100 + i), W'(100 + i));
        idle(4);
        chk(got.size() == 8, "R2 stream size", got.size(), 8);
        for (int i = 0; i < 8 && i < got.size(); i++)
            chk(got[i] == W'(100 + i), "R2 stream order", got[i], 100 + i);
        chk(err_count == c0, "R6 no errors", err_count, c0);
    endtask

    task automatic t_single_err();
        int c0 = err_count;
        push(16'h00A0, 16'h00A1);
        chk(err == 1, "R3 err", err, 1);
        chk(stall == 1 && bubble == 1, "R3 stall+bubble", {stall, bubble}, 3);
        step();
        chk(out_valid == 0, "R4 bubble slot", out_valid, 0);
        chk(err == 0, "R4 err cleared", err, 0);
        step();
        chk(out_valid == 1 && out_data == 16'h00A1, "R4 shadow value", out_data, 16'h00A1);
        chk(err_count == c0 + 1, "R6 count +1", err_count, c0 + 1);
        idle(2);
    endtask

    task automatic t_err_stream();
        int c0 = err_count;
        got.delete();
        for (int i = 0; i < 8; i++) begin
            bit bad = (i == 2) || (i == 3) || (i == 6);
            push(W'(200 + i), bad ? W'(300 + i) : W'(200 + i));
        end
        idle(4);
        chk(got.size() == 8, "R5 no loss/dup", got.size(), 8);
        for (int i = 0; i < 8 && i < got.size(); i++) begin
            bit bad = (i == 2) || (i == 3) || (i == 6);
            int e = bad ? 300 + i : 200 + i;
            chk(got[i] == W'(e), "R5 order/R4 values", got[i], e);
        end
        chk(err_count == c0 + 3, "R6 count +3", err_count, c0 + 3);
    endtask

    task automatic t_invalid();
        int c0 = err_count;
        in_valid = 1'b0; in_data = 16'h0F0F; late_data = 16'hF0F0;
        step();
        chk(err == 0, "R9 invalid no err", err, 0);
        step();
        chk(err == 0 && out_valid == 0, "R9 still quiet", {err, out_valid}, 0);
        chk(err_count == c0, "R9 count unchanged", err_count, c0);
        idle(1);
    endtask

    task automatic t_flush();
        int ns = 0;
        got.delete();
        push(16'h0501, 16'h0501);
        push(16'h0502, 16'h0502);
        in_valid = 1'b1; in_data = 16'h0503; late_data = 16'h0503; flush_req = 1'b1;
        step();
        flush_req = 1'b0; in_valid = 1'b0;
        chk(out_valid == 0, "R7 flushed out", out_valid, 0);
        for (int i = 0; i < 4; i++) begin
            if (stall) ns++;
            step();
        end
        chk(ns == 2, "R7 stall cycles", ns, 2);
        chk(got.size() == 1, "R7 in-flight dropped", got.size(), 1);
        push(16'h0502, 16'h0502);
        push(16'h0503, 16'h0503);
        idle(3);
        chk(got.size() == 3 && got[got.size()-1] == 16'h0503, "R7 replay", got.size(), 3);
    endtask

    task automatic t_flush_err();
        int c0 = err_count;
        push(16'h0700, 16'h0707);
        chk(err == 1, "R8 err seen", err, 1);
        flush_req = 1'b1;
        #0.1;
        chk(stall == 0 && bubble == 0, "R8 no stall under flush", {stall, bubble}, 0);
        step();
        flush_req = 1'b0;
        chk(err_count == c0, "R8 count unchanged", err_count, c0);
        chk(err == 0 && out_valid == 0, "R8 flushed", {err, out_valid}, 0);
        idle(4);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 260; i++) push(W'(i), W'(i) ^ 16'h8000);
        idle(3);
        chk(err_count == 8'd255, "R6 saturation", err_count, 255);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0 && err_count == 0, "R1 during reset", out_valid, 0);
        rst_n = 1'b1;
        step();
        t_reset();
        t_latency();
        t_clean_stream();
        t_single_err();
        t_err_stream();
        t_invalid();
        t_flush();
        t_flush_err();
        t_saturate();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule